// File: doc/BRIEF.md
# Power-of-Two Output Clock Divider

This block divides a fast synthesizer clock by 2, 4, 8 or 16 and drives a true and complement output pair. The output always has a 50% duty cycle. A 2-bit ratio code selects the division, and it normally comes from a configuration register held elsewhere on the chip. The same fast clock runs the whole block. A synchronous reset clears it.

The block never shows a shortened high or low phase. To achieve this, the ratio code and the active-high output enable are both sampled only at the boundary between two output periods. An output period always starts with its high phase. When the output is disabled, the pair rests with the true output low and the complement output high.

While the output is disabled, every cycle counts as a boundary. Because of this, a raised enable is seen on the next clock edge, and the output starts a full-length high phase at once. Each interface pin is a plain level. Data is never transferred as a stream, so the block has no valid/ready handshake and no back-pressure.

Top module: `vco_out_divider`

## Requirements
- R1: The ratio code sets the output period in fast-clock cycles: code 0 gives 2, code 1 gives 4, code 2 gives 8 and code 3 gives 16, that is 2^(code+1).
- R2: At every ratio, each high phase and each low phase of a running output lasts exactly half the period, 2^code cycles.
- R3: The complement output equals the inverse of the true output in every cycle, including during reset and while disabled.
- R4: While reset is sampled high, the true output is low and the complement is high from the next edge onward. After reset is released with the enable high, the output starts a full high phase on the first edge at which reset is sampled low.
- R5: While disabled, the true output stays low and the complement stays high, whatever the ratio code does.
- R6: Lowering the enable while running does not cut the period in progress. Its high and low phases both complete at full length, and only then does the output stay low.
- R7: From the disabled state, an enable sampled high on a clock edge makes the true output high from that edge. The first high phase and the first low phase then each last 2^code cycles.
- R8: A new ratio code takes effect only at a period boundary. The period in progress completes at the old ratio, and the next period starts with a high phase at the new ratio.
- R9: Changes of the enable or the ratio code that are reversed before the current period ends have no effect on the output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fast (VCO) clock that runs the divider |
| rst_i | input | 1 | Synchronous reset, active high |
| ratio_sel_i | input | SEL_W (2) | Ratio code: 0 gives /2, 1 gives /4, 2 gives /8, 3 gives /16 |
| enable_i | input | 1 | Output enable, active high, applied at period boundaries |
| clk_out_p_o | output | 1 | Divided clock, true output |
| clk_out_n_o | output | 1 | Divided clock, complement output |

## Verification
The hardest situation to reach from the ports is a ratio or enable change that arrives immediately after a period boundary. The new value then has to wait through an entire period at the old ratio. The bench reaches this by tracking the output on falling clock edges. On the first sample that shows a new high phase, it drives the new code and then measures four phase lengths in a row, for all sixteen pairs of old and new codes. A separate case glitches both inputs deep inside a slow period and restores them before the boundary. The phase lengths measured afterwards show that the glitch left no trace.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;

  // Default code width: four ratios, /2 through /16.
  localparam int unsigned SEL_W_DEF = 2;

  // Names for the default ratio codes.
  typedef enum logic [SEL_W_DEF-1:0] {
    RATIO_DIV2  = 2'd0,
    RATIO_DIV4  = 2'd1,
    RATIO_DIV8  = 2'd2,
    RATIO_DIV16 = 2'd3
  } ratio_code_e;

  // Cycles in one half period for a given code.
  function automatic int unsigned half_cycles(input int unsigned code);
    return 32'd1 << code;
  endfunction

endpackage

// File: rtl/clkdiv_ctrl.sv
module clkdiv_ctrl #(
  parameter int unsigned SEL_W = 2,
  parameter int unsigned CW    = 4
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic [SEL_W-1:0] ratio_sel_i,
  input  logic             enable_i,
  input  logic [CW-1:0]    cnt_q_i,
  output logic             wrap_o,
  output logic [SEL_W-1:0] sel_q_o,
  output logic [SEL_W-1:0] sel_nxt_o,
  output logic             run_nxt_o,
  output logic             run_q_o
);
  localparam int unsigned NCODES = 1 << SEL_W;

  logic [CW-1:0] mask_tbl [NCODES];
  logic [CW-1:0] mask_cur;
  logic [SEL_W-1:0] sel_q;
  logic run_q;

  // Last count value of a period for each code: 2^(code+1)-1.
  for (genvar g = 0; g < NCODES; g++) begin : g_mask
    assign mask_tbl[g] = CW'((64'd2 << g) - 64'd1);
  end

  assign mask_cur = mask_tbl[sel_q];
  // While idle, every cycle counts as a period boundary.
  assign wrap_o    = !run_q || ((cnt_q_i & mask_cur) == mask_cur);
  assign sel_nxt_o = wrap_o ? ratio_sel_i : sel_q;
  assign run_nxt_o = wrap_o ? enable_i : run_q;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      sel_q <= '0;
      run_q <= 1'b0;
    end else begin
      sel_q <= sel_nxt_o;
      run_q <= run_nxt_o;
    end
  end

  assign sel_q_o = sel_q;
  assign run_q_o = run_q;

  AST_CNT_IN_RATIO: assert property (@(posedge clk_i) disable iff (rst_i)
    (cnt_q_i & ~mask_cur) == '0); // R1

endmodule

// File: rtl/clkdiv_cnt.sv
module clkdiv_cnt #(
  parameter int unsigned CW = 4
) (
  input  logic          clk_i,
  input  logic          rst_i,
  input  logic          wrap_i,
  output logic [CW-1:0] cnt_q_o,
  output logic [CW-1:0] cnt_nxt_o
);
  logic [CW-1:0] cnt_q;

  // The count returns to zero at each period boundary, so a new period
  // always starts with a high phase.
  assign cnt_nxt_o = wrap_i ? '0 : cnt_q + CW'(1);

  always_ff @(posedge clk_i) begin
    if (rst_i) cnt_q <= '0;
    else       cnt_q <= cnt_nxt_o;
  end

  assign cnt_q_o = cnt_q;

endmodule

// File: rtl/clkdiv_outstage.sv
module clkdiv_outstage #(
  parameter int unsigned SEL_W = 2,
  parameter int unsigned CW    = 4
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic             run_nxt_i,
  input  logic [SEL_W-1:0] sel_nxt_i,
  input  logic [CW-1:0]    cnt_nxt_i,
  output logic             p_o,
  output logic             n_o
);
  localparam int unsigned NCODES = 1 << SEL_W;

  logic [NCODES-1:0] phase_bits;
  logic level;
  logic p_q, n_q;

  // Code g reads count bit g, inverted so the period opens high.
  for (genvar g = 0; g < NCODES; g++) begin : g_phase
    assign phase_bits[g] = ~cnt_nxt_i[g];
  end

  assign level = run_nxt_i & phase_bits[sel_nxt_i];

  // Separate, matched flops for the true and complement outputs.
  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      p_q <= 1'b0;
      n_q <= 1'b1;
    end else begin
      p_q <= level;
      n_q <= ~level;
    end
  end

  assign p_o = p_q;
  assign n_o = n_q;

  AST_PAIR_COMPLEMENT: assert property (@(posedge clk_i) disable iff (rst_i)
    n_q == !p_q); // R3

endmodule

// File: rtl/vco_out_divider.sv
module vco_out_divider #(
  parameter int unsigned SEL_W = clkdiv_pkg::SEL_W_DEF
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic [SEL_W-1:0] ratio_sel_i,
  input  logic             enable_i,
  output logic             clk_out_p_o,
  output logic             clk_out_n_o
);
  localparam int unsigned CW = 1 << SEL_W;

  logic             wrap;
  logic [SEL_W-1:0] sel_q, sel_nxt;
  logic             run_nxt, run_q;
  logic [CW-1:0]    cnt_q, cnt_nxt;

  clkdiv_ctrl #(.SEL_W(SEL_W), .CW(CW)) i_ctrl (
    .clk_i       (clk_i),
    .rst_i       (rst_i),
    .ratio_sel_i (ratio_sel_i),
    .enable_i    (enable_i),
    .cnt_q_i     (cnt_q),
    .wrap_o      (wrap),
    .sel_q_o     (sel_q),
    .sel_nxt_o   (sel_nxt),
    .run_nxt_o   (run_nxt),
    .run_q_o     (run_q)
  );

  clkdiv_cnt #(.CW(CW)) i_cnt (
    .clk_i     (clk_i),
    .rst_i     (rst_i),
    .wrap_i    (wrap),
    .cnt_q_o   (cnt_q),
    .cnt_nxt_o (cnt_nxt)
  );

  clkdiv_outstage #(.SEL_W(SEL_W), .CW(CW)) i_out (
    .clk_i     (clk_i),
    .rst_i     (rst_i),
    .run_nxt_i (run_nxt),
    .sel_nxt_i (sel_nxt),
    .cnt_nxt_i (cnt_nxt),
    .p_o       (clk_out_p_o),
    .n_o       (clk_out_n_o)
  );

  // Phase-length tracker used only by the checks below.
  logic          prev_p;
  logic [CW:0]   len_q;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      prev_p <= 1'b0;
      len_q  <= '0;
    end else begin
      prev_p <= clk_out_p_o;
      len_q  <= (clk_out_p_o != prev_p) ? (CW+1)'(1) : len_q + (CW+1)'(1);
    end
  end

  AST_HIGH_PHASE_WIDTH: assert property (@(posedge clk_i) disable iff (rst_i)
    (prev_p && !clk_out_p_o) |-> (len_q == ((CW+1)'(1) << sel_q))); // R2

  AST_RISE_AT_PERIOD_START: assert property (@(posedge clk_i) disable iff (rst_i)
    $rose(clk_out_p_o) |-> (cnt_q == '0)); // R8

  AST_LOW_WHEN_IDLE: assert property (@(posedge clk_i) disable iff (rst_i)
    !run_q |-> (!clk_out_p_o && clk_out_n_o)); // R5

  AST_RUN_FOLLOWS_ENABLE: assert property (@(posedge clk_i) disable iff (rst_i)
    (!run_q && enable_i) |=> clk_out_p_o); // R7

endmodule

// File: tb/test_vco_out_divider.sv
module test_vco_out_divider;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] sel = 2'd0;
  logic       en  = 1'b0;
  logic       p, n;

  int total = 0;
  int fails = 0;
  int cmp_err = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  vco_out_divider i_vco_out_divider (
    .clk_i       (clk),
    .rst_i       (rst),
    .ratio_sel_i (sel),
    .enable_i    (en),
    .clk_out_p_o (p),
    .clk_out_n_o (n)
  );

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // R3 is watched on every sample taken.
  task automatic look();
    if (n !== ~p) cmp_err++;
  endtask

  // Count consecutive samples at level lvl, starting at the current one.
  task automatic run_len(input logic lvl, output int cnt);
    cnt = 0;
    look();
    while (p === lvl && cnt < 100) begin
      cnt++;
      @(negedge clk);
      look();
    end
  endtask

  // Move forward to the first sample of a new high phase.
  task automatic sync_rise();
    int guard = 0;
    while (p === 1'b1 && guard < 100) begin @(negedge clk); guard++; end
    while (p === 1'b0 && guard < 200) begin @(negedge clk); guard++; end
  endtask

  initial begin
    int h, l, hi_seen;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R4 reset true out", p, 0);
    chk("R4 reset complement", n, 1);
    rst = 1'b0;

    // R5: idle with the code changing
    hi_seen = 0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk); look();
      sel = 2'(i);
      if (p) hi_seen++;
    end
    chk("R5 idle stays low", hi_seen, 0);

    for (int k = 0; k < 4; k++) begin
      sel = 2'(k);
      @(negedge clk);
      en = 1'b1;
      @(negedge clk);
      run_len(1'b1, h); chk($sformatf("R7 first high code %0d", k), h, 1 << k);
      run_len(1'b0, l); chk($sformatf("R7 first low code %0d", k), l, 1 << k);
      for (int r = 0; r < 3; r++) begin
        run_len(1'b1, h); chk($sformatf("R2 high code %0d", k), h, 1 << k);
        run_len(1'b0, l); chk($sformatf("R1 period code %0d", k), h + l, 2 << k);
      end
      // R6: drop enable at the start of a period
      en = 1'b0;
      run_len(1'b1, h); chk($sformatf("R6 last high code %0d", k), h, 1 << k);
      hi_seen = 0;
      for (int i = 0; i < (1 << k) + 6; i++) begin
        if (p) hi_seen++;
        @(negedge clk); look();
      end
      chk($sformatf("R6 low then hold code %0d", k), hi_seen, 0);
    end

    // R9: glitches that are undone before the boundary
    sel = 2'd3; en = 1'b1;
    sync_rise(); sync_rise();
    fork
      begin
        repeat (2) @(negedge clk);
        en = 1'b0; sel = 2'd0;
        @(negedge clk);
        sel = 2'd2;
        @(negedge clk);
        en = 1'b1; sel = 2'd3;
      end
      begin
        run_len(1'b1, h); chk("R9 high after glitch", h, 8);
        run_len(1'b0, l); chk("R9 low after glitch", l, 8);
        run_len(1'b1, h); chk("R9 next high", h, 8);
      end
    join

    // R8: every pair of old and new codes
    for (int a = 0; a < 4; a++) begin
      for (int b = 0; b < 4; b++) begin
        int h1, l1, h2, l2;
        sel = 2'(a);
        sync_rise(); sync_rise();
        sel = 2'(b);
        run_len(1'b1, h1);
        run_len(1'b0, l1);
        run_len(1'b1, h2);
        run_len(1'b0, l2);
        chk($sformatf("R8 %0d->%0d old high", a, b), h1, 1 << a);
        chk($sformatf("R8 %0d->%0d old low", a, b), l1, 1 << a);
        chk($sformatf("R8 %0d->%0d new high", a, b), h2, 1 << b);
        chk($sformatf("R8 %0d->%0d new low", a, b), l2, 1 << b);
      end
    end

    // R4: reset while running, release with enable high
    sel = 2'd1;
    sync_rise();
    rst = 1'b1;
    @(negedge clk);
    chk("R4 reset mid-run true", p, 0);
    chk("R4 reset mid-run complement", n, 1);
    @(negedge clk);
    chk("R4 reset held true", p, 0);
    rst = 1'b0;
    @(negedge clk);
    run_len(1'b1, h); chk("R4 high after release", h, 2);

    chk("R3 complement mismatches", cmp_err, 0);
    done = 1'b1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

endmodule